// File: doc/BRIEF.md
# Logarithmic Multiply, Divide and Square-Root Unit

This block computes an approximate product, quotient or square root of unsigned integers. It works in a fixed-point base-2 log domain. Each operand is written as 2^k·(1+x). The log approximation k+x comes from the leading-one position and the bits beneath it. A single shared adder then combines the two logs. It adds them for a product, subtracts them for a quotient, and adds zero and halves the sum for a root.

A small correction, read from a constant table, is added to the combined log. The table is addressed by the three most significant fraction bits of each operand. The corrected log is converted back to an integer and rounded to the nearest whole number. A fully pipelined datapath takes one operation per cycle and returns every result six register stages later, whatever the command. It suits DSP pipelines that accept a small relative error in exchange for dropping full multipliers, dividers and root extractors.

Top module: `logmath_unit`

## Requirements
- R1: A request with `in_valid` high at rising edge n gives `out_valid` high after rising edge n+5. A new request is accepted on every edge, and results leave in request order.
- R2: With `cmd`=00 (multiply) and both operands nonzero, the corrected log is log(a)+log(b)+Cm(ia,ib). The result is the antilog of that value.
- R3: With `cmd`=01 (divide), a nonzero and b nonzero, the corrected log is log(a)−log(b)+Cd(ia,ib). The result is the antilog of that value.
- R4: With `cmd[1]`=1 (square root, 10 and 11 alike), `op_b` has no effect. The corrected log is floor(log(a)/2 in LSB units)+Cr(k[0],ia). The result is the antilog of that value.
- R5: log(v) = k·2^F + x·2^F, with F=`FRAC_W` and x the OP_W−1 bits below the leading one, taken as a fraction. The region index i is the top three bits of x.
- R6: With m=(2i+1)/16 and n=(2j+1)/16, Cm = floor(m·n·2^F) when i+j<7, and floor((1−m)(1−n)/2·2^F) otherwise.
- R7: Cd = floor(2^F·(1+m)/(1+n)) − floor(2^F·(1+m−n)) when i≥j. Otherwise Cd = floor(2^(F+1)·(1+m)/(1+n)) − floor(2^F·(2+m−n)). Cd is never positive.
- R8: Cr = isqrt(2^(2F)·(1+m)) − 2^F − floor(2^F·m/2) for even k. For odd k, Cr = isqrt(2^(2F+1)·(1+m)) − floor(2^F·(3+m)/2).
- R9: A multiply with either operand zero, a root of zero, and a divide of zero by nonzero all return 0 with `out_err` low.
- R10: A divide by zero returns all ones with `out_err` high. `out_err` is low for every other result.
- R11: The antilog of corrected log y splits y into a signed integer part e and a fraction f. If e<−1 the result is 0. Otherwise it is floor(2^e·(1+f)+1/2), held at all ones when it would exceed 2·OP_W bits.
- R12: While `rst` is high at a rising edge, `out_valid`, `out_err` and `out_res` are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| cmd | input | 2 | 00 multiply, 01 divide, 1x square root |
| op_a | input | OP_W | Multiplicand, dividend or radicand |
| op_b | input | OP_W | Multiplier or divisor, unused for root |
| out_valid | output | 1 | Result strobe |
| out_res | output | 2*OP_W | Rounded result |
| out_err | output | 1 | Divide-by-zero flag |

## Verification
The output stage can apply a zero or divide-by-zero override to one slot in the same cycle that the correction table is read for a different command in a following slot. A mistake in carrying the flags or the table bank between slots shows up only in that overlap. Gap-free streams mixing all three commands with frequent zero operands provoke it. Every slot is judged against a bench model of the log, correction and antilog arithmetic, including the error flag. Directed cases cover exact powers of two, a divisor larger than the dividend, and root requests whose second operand is nonzero.

// File: rtl/logmath_pkg.sv
`timescale 1ns/1ps
package logmath_pkg;

  localparam int REGION_BITS = 3;
  localparam int ROM_AW      = 8;

  typedef struct packed {
    logic       v;
    logic [1:0] cmd;
    logic       za;
    logic       zb;
  } lm_tag_t;

  function automatic longint isqrt(longint n);
    longint r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction

  // Correction table content: bank 0 multiply, 1 divide, 2 root (parity, region)
  function automatic int corr_entry(int addr, int fw);
    longint s = longint'(1) << fw;
    longint c = 0;
    int bank = addr >> 6;
    int i = (addr >> 3) & 7;
    int j = addr & 7;
    if (bank == 0) begin
      if (i + j < 7) c = (longint'((2*i+1)*(2*j+1)) * s) / 256;
      else           c = (longint'((15-2*i)*(15-2*j)) * s) / 512;
    end else if (bank == 1) begin
      if (i >= j) c = (longint'(17+2*i) * s) / (17+2*j) - (longint'(16+2*i-2*j) * s) / 16;
      else        c = (longint'(2*(17+2*i)) * s) / (17+2*j) - (longint'(32+2*i-2*j) * s) / 16;
    end else if (bank == 2) begin
      if (i == 0) c = isqrt((longint'(17+2*j) * s * s) / 16) - s - (longint'(2*j+1) * s) / 32;
      else if (i == 1) c = isqrt((longint'(2*(17+2*j)) * s * s) / 16) - (longint'(49+2*j) * s) / 32;
    end
    return int'(c);
  endfunction

endpackage

// File: rtl/logmath_log2.sv
`timescale 1ns/1ps
module logmath_log2 #(
  parameter int OP_W   = 8,
  parameter int FRAC_W = 12,
  parameter int LOG_W  = 17
) (
  input  logic [OP_W-1:0]  val,
  output logic [LOG_W-1:0] lg,
  output logic [2:0]       region,
  output logic             is_zero
);
  localparam int KW = $clog2(OP_W);

  logic [KW-1:0]   lead;
  logic [OP_W-2:0] frac;

  // priority encoder: highest set bit wins
  always_comb begin
    lead = '0;
    for (int i = 0; i < OP_W; i++)
      if (val[i]) lead = KW'(i);
  end

  // barrel shift the bits under the leading one to the top of the fraction
  assign frac    = (OP_W-1)'(val << (KW'(OP_W-1) - lead));
  assign region  = frac[OP_W-2 -: 3];
  assign is_zero = ~|val;
  assign lg      = (LOG_W'(lead) << FRAC_W) | (LOG_W'(frac) << (FRAC_W - OP_W + 1));

endmodule

// File: rtl/logmath_corr_rom.sv
`timescale 1ns/1ps
module logmath_corr_rom
  import logmath_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int CORR_W = 17
) (
  input  logic                     clk,
  input  logic [ROM_AW-1:0]        addr,
  output logic signed [CORR_W-1:0] corr
);
  localparam int DEPTH = 1 << ROM_AW;

  logic signed [CORR_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign rom[g] = CORR_W'(corr_entry(g, FRAC_W));
  end

  always_ff @(posedge clk) corr <= rom[addr];

endmodule

// File: rtl/logmath_antilog.sv
`timescale 1ns/1ps
module logmath_antilog #(
  parameter int FRAC_W = 12,
  parameter int IW     = 5,
  parameter int RES_W  = 16
) (
  input  logic signed [IW+FRAC_W-1:0] lg,
  output logic [RES_W-1:0]            mag
);
  localparam int WW = FRAC_W + RES_W + 2;

  logic signed [IW-1:0] ex;
  logic [FRAC_W-1:0]    fr;
  logic [WW-1:0]        wide;
  logic [RES_W:0]       q;

  assign ex = lg[IW+FRAC_W-1 -: IW];
  assign fr = lg[FRAC_W-1:0];

  always_comb begin
    wide = '0;
    q    = '0;
    if (ex < -1) begin
      mag = '0;
    end else if (int'(ex) >= RES_W) begin
      mag = '1;
    end else begin
      // (1+f) placed at bit e, then round half up
      wide = (WW'({1'b1, fr}) << (IW'(ex) + IW'(1))) + (WW'(1) << FRAC_W);
      q    = (RES_W+1)'(wide >> (FRAC_W + 1));
      mag  = q[RES_W] ? '1 : q[RES_W-1:0];
    end
  end

endmodule

// File: rtl/logmath_unit.sv
`timescale 1ns/1ps
module logmath_unit
  import logmath_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int FRAC_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           cmd,
  input  logic [OP_W-1:0]      op_a,
  input  logic [OP_W-1:0]      op_b,
  output logic                 out_valid,
  output logic [2*OP_W-1:0]    out_res,
  output logic                 out_err
);
  localparam int RES_W = 2 * OP_W;
  localparam int IW    = $clog2(RES_W) + 1;
  localparam int LOG_W = IW + FRAC_W;

  // stage 1: operand capture
  logic [OP_W-1:0] s1_a, s1_b;
  logic [1:0]      s1_cmd;
  logic            s1_v;
  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_a   <= op_a;
    s1_b   <= op_b;
    s1_cmd <= cmd;
  end

  // stage 2: log conversion, second input is the constant one for root
  logic [OP_W-1:0]  b_src;
  logic [LOG_W-1:0] la, lb;
  logic [2:0]       ia, ib;
  logic             za, zb;
  assign b_src = s1_cmd[1] ? OP_W'(1) : s1_b;

  logmath_log2 #(.OP_W(OP_W), .FRAC_W(FRAC_W), .LOG_W(LOG_W)) u_log_a (
    .val(s1_a), .lg(la), .region(ia), .is_zero(za));
  logmath_log2 #(.OP_W(OP_W), .FRAC_W(FRAC_W), .LOG_W(LOG_W)) u_log_b (
    .val(b_src), .lg(lb), .region(ib), .is_zero(zb));

  lm_tag_t          s2_t;
  logic [LOG_W-1:0] s2_la, s2_lb;
  logic [2:0]       s2_ia, s2_ib;
  always_ff @(posedge clk) begin
    if (rst) s2_t.v <= 1'b0;
    else     s2_t.v <= s1_v;
    s2_t.cmd <= s1_cmd;
    s2_t.za  <= za;
    s2_t.zb  <= zb;
    s2_la    <= la;
    s2_lb    <= lb;
    s2_ia    <= ia;
    s2_ib    <= ib;
  end

  // stage 3: one adder for add/subtract via LSB padding, then optional halving
  logic             sub;
  logic [LOG_W:0]   padded;
  logic [LOG_W-1:0] raw, combined;
  logic [ROM_AW-1:0] rom_addr;
  assign sub      = s2_t.cmd[0];
  assign padded   = {s2_la, 1'b1} + {s2_lb ^ {LOG_W{sub}}, sub};
  assign raw      = padded[LOG_W:1];
  assign combined = s2_t.cmd[1] ? {raw[LOG_W-1], raw[LOG_W-1:1]} : raw;
  assign rom_addr = s2_t.cmd[1] ? {2'b10, 2'b00, s2_la[FRAC_W], s2_ia}
                                : {1'b0, s2_t.cmd[0], s2_ia, s2_ib};

  logic signed [LOG_W-1:0] s3_corr;
  logmath_corr_rom #(.FRAC_W(FRAC_W), .CORR_W(LOG_W)) u_rom (
    .clk(clk), .addr(rom_addr), .corr(s3_corr));

  lm_tag_t                 s3_t;
  logic signed [LOG_W-1:0] s3_sum;
  always_ff @(posedge clk) begin
    if (rst) s3_t.v <= 1'b0;
    else     s3_t.v <= s2_t.v;
    s3_t.cmd <= s2_t.cmd;
    s3_t.za  <= s2_t.za;
    s3_t.zb  <= s2_t.zb;
    s3_sum   <= combined;
  end

  // stage 4: apply correction in the log domain
  lm_tag_t                 s4_t;
  logic signed [LOG_W-1:0] s4_log;
  always_ff @(posedge clk) begin
    if (rst) s4_t.v <= 1'b0;
    else     s4_t.v <= s3_t.v;
    s4_t.cmd <= s3_t.cmd;
    s4_t.za  <= s3_t.za;
    s4_t.zb  <= s3_t.zb;
    s4_log   <= s3_sum + s3_corr;
  end

  // stage 5: antilog
  logic [RES_W-1:0] mag;
  logmath_antilog #(.FRAC_W(FRAC_W), .IW(IW), .RES_W(RES_W)) u_alog (
    .lg(s4_log), .mag(mag));

  lm_tag_t          s5_t;
  logic [RES_W-1:0] s5_mag;
  always_ff @(posedge clk) begin
    if (rst) s5_t.v <= 1'b0;
    else     s5_t.v <= s4_t.v;
    s5_t.cmd <= s4_t.cmd;
    s5_t.za  <= s4_t.za;
    s5_t.zb  <= s4_t.zb;
    s5_mag   <= mag;
  end

  // stage 6: zero and divide-by-zero overrides, registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s5_t.v;
      out_err   <= 1'b0;
      if (s5_t.cmd[1])
        out_res <= s5_t.za ? '0 : s5_mag;
      else if (!s5_t.cmd[0])
        out_res <= (s5_t.za || s5_t.zb) ? '0 : s5_mag;
      else if (s5_t.zb) begin
        out_res <= '1;
        out_err <= s5_t.v;
      end else
        out_res <= s5_t.za ? '0 : s5_mag;
    end
  end

endmodule

// File: rtl/logmath_unit_chk.sv
`timescale 1ns/1ps
module logmath_unit_chk #(
  parameter int OP_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [1:0]          cmd,
  input logic [OP_W-1:0]     op_a,
  input logic [OP_W-1:0]     op_b,
  input logic                out_valid,
  input logic [2*OP_W-1:0]   out_res,
  input logic                out_err
);
  localparam int RES_W = 2 * OP_W;

  logic [5:0] v_sr, z_sr, d_sr, r_sr;
  logic       zero_case, dz_case;

  assign zero_case = (cmd == 2'b00 && (op_a == '0 || op_b == '0)) ||
                     (cmd[1] && op_a == '0) ||
                     (cmd == 2'b01 && op_a == '0 && op_b != '0);
  assign dz_case   = (cmd == 2'b01) && (op_b == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sr <= '0; z_sr <= '0; d_sr <= '0; r_sr <= '0;
    end else begin
      v_sr <= {v_sr[4:0], in_valid};
      z_sr <= {z_sr[4:0], in_valid && zero_case};
      d_sr <= {d_sr[4:0], in_valid && dz_case};
      r_sr <= {r_sr[4:0], in_valid && cmd[1]};
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sr[5]);

  // R9
  zero_res_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_sr[5]) |-> (out_res == '0 && !out_err));

  // R10
  divzero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && d_sr[5]) |-> (&out_res && out_err));

  // R10
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && d_sr[5]));

  // R4
  root_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && r_sr[5]) |-> (out_res[RES_W-1:OP_W] == '0));

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_res == '0));

endmodule

bind logmath_unit logmath_unit_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cmd(cmd), .op_a(op_a),
  .op_b(op_b), .out_valid(out_valid), .out_res(out_res), .out_err(out_err));

// File: tb/logmath_unit_test.sv
`timescale 1ns/1ps
module logmath_unit_test;
  localparam int L  = 8;
  localparam int FW = 12;
  localparam int RW = 2 * L;
  localparam longint S = longint'(1) << FW;
  localparam longint ALL1 = (longint'(1) << RW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [L-1:0]  op_a = '0, op_b = '0;
  logic          out_valid;
  logic [RW-1:0] out_res;
  logic          out_err;

  always #2.5 clk = ~clk;

  logmath_unit #(.OP_W(L), .FRAC_W(FW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cmd(cmd), .op_a(op_a),
    .op_b(op_b), .out_valid(out_valid), .out_res(out_res), .out_err(out_err));

  int checks = 0, fails = 0;
  bit done = 0;

  bit     rv[6];
  longint rres[6];
  bit     rerr[6];
  string  rtag[6];
  int     ra[6], rb[6], rc[6];

  function automatic longint isq(longint n);
    longint r = longint'($floor($sqrt(real'(n))));
    while (r * r > n) r--;
    while ((r + 1) * (r + 1) <= n) r++;
    return r;
  endfunction

  // R6 multiply correction
  function automatic longint mulc(int i, int j);
    if (i + j < 7) return (longint'((2*i+1)*(2*j+1)) * S) / 256;
    return (longint'((15-2*i)*(15-2*j)) * S) / 512;
  endfunction

  // R7 divide correction
  function automatic longint divc(int i, int j);
    longint num = 17 + 2*i, den = 17 + 2*j;
    if (i >= j) return (num * S) / den - (longint'(16+2*i-2*j) * S) / 16;
    return (2 * num * S) / den - (longint'(32+2*i-2*j) * S) / 16;
  endfunction

  // R8 root correction
  function automatic longint rtc(int odd, int i);
    if (odd == 0) return isq((longint'(17+2*i) * S * S) / 16) - S - (longint'(2*i+1) * S) / 32;
    return isq((longint'(34+4*i) * S * S) / 16) - (longint'(49+2*i) * S) / 32;
  endfunction

  // R5 log conversion
  task automatic to_log(input int v, output longint lgv, output int idx, output int k);
    int frac;
    k = 0;
    for (int b = 0; b < L; b++) if (((v >> b) & 1) != 0) k = b;
    frac = (v << (L-1-k)) & ((1 << (L-1)) - 1);
    lgv  = longint'(k) * S + longint'(frac) * (S >> (L-1));
    idx  = frac >> (L-4);
  endtask

  // R11 antilog with round half up
  function automatic longint antilog(longint y);
    longint e = y >>> FW;
    longint f = y - (e <<< FW);
    longint q;
    if (e < -1) return 0;
    if (e >= RW) return ALL1;
    q = (((S + f) << (e + 1)) + S) >> (FW + 1);
    return (q > ALL1) ? ALL1 : q;
  endfunction

  task automatic model(input int a, input int b, input int c,
                       output longint res, output bit err, output string tag);
    longint la, lb, y;
    int ia, ib, ka, kb;
    err = 0;
    to_log(a, la, ia, ka);
    to_log(b, lb, ib, kb);
    if (c >= 2) begin
      tag = "R4 R8";
      if (a == 0) begin res = 0; tag = "R9"; end
      else begin y = (la >>> 1) + rtc(ka & 1, ia); res = antilog(y); end
    end else if (c == 0) begin
      tag = "R2 R5 R6";
      if (a == 0 || b == 0) begin res = 0; tag = "R9"; end
      else res = antilog(la + lb + mulc(ia, ib));
    end else begin
      tag = "R3 R7";
      if (b == 0) begin res = ALL1; err = 1; tag = "R10"; end
      else if (a == 0) begin res = 0; tag = "R9"; end
      else begin
        y = la - lb + divc(ia, ib);
        if ((y >>> FW) < -1) tag = "R11";
        res = antilog(y);
      end
    end
  endtask

  task automatic step(input bit v, input int c, input int a, input int b);
    @(negedge clk);
    checks++;
    if (out_valid !== rv[5]) begin
      fails++;
      $display("FAIL R1: out_valid actual=%0b expected=%0b", out_valid, rv[5]);
    end
    if (rv[5]) begin
      checks++;
      if (out_res !== rres[5][RW-1:0] || out_err !== rerr[5]) begin
        fails++;
        $display("FAIL %s: cmd=%0d a=%0d b=%0d actual res=%0d err=%0b expected res=%0d err=%0b",
                 rtag[5], rc[5], ra[5], rb[5], out_res, out_err, rres[5], rerr[5]);
      end
    end
    for (int i = 5; i > 0; i--) begin
      rv[i] = rv[i-1]; rres[i] = rres[i-1]; rerr[i] = rerr[i-1];
      rtag[i] = rtag[i-1]; ra[i] = ra[i-1]; rb[i] = rb[i-1]; rc[i] = rc[i-1];
    end
    rv[0] = v; ra[0] = a; rb[0] = b; rc[0] = c;
    model(a, b, c, rres[0], rerr[0], rtag[0]);
    in_valid = v;
    cmd      = 2'(c);
    op_a     = L'(a);
    op_b     = L'(b);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) begin
      rv[i] = 0; rres[i] = 0; rerr[i] = 0; rtag[i] = ""; ra[i] = 0; rb[i] = 0; rc[i] = 0;
    end
    in_valid = 1'b1;
    cmd = 2'b01;
    op_b = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12 outputs held clear during reset even with requests on the inputs
    checks++;
    if (out_valid !== 1'b0 || out_err !== 1'b0 || out_res !== '0) begin
      fails++;
      $display("FAIL R12: actual v=%0b err=%0b res=%0h expected 0 0 0", out_valid, out_err, out_res);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // directed corners
    step(1, 0, 0, 5);      // R9
    step(1, 0, 5, 0);      // R9
    step(1, 0, 255, 255);  // R2 top of range
    step(1, 0, 1, 1);
    step(1, 0, 3, 5);
    step(1, 0, 128, 64);   // exact powers
    step(1, 1, 15, 3);     // R3
    step(1, 1, 7, 0);      // R10
    step(1, 1, 0, 9);      // R9
    step(1, 1, 1, 255);    // R11
    step(1, 1, 1, 3);      // R11
    step(1, 1, 1, 2);
    step(1, 1, 255, 1);
    step(1, 2, 0, 77);     // R9 root of zero
    step(1, 2, 1, 0);      // R4
    step(1, 2, 4, 0);
    step(1, 2, 255, 0);
    step(1, 2, 200, 13);   // R4 op_b ignored
    step(1, 3, 200, 250);  // R4 cmd 11 same as 10
    step(1, 3, 100, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // constrained random stream, mostly gap-free
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 8);
      int c = (r < 3) ? 0 : (r < 6) ? 1 : (r == 6) ? 2 : 3;
      int a = int'($urandom % 256);
      int b = int'($urandom % 256);
      bit v = (($urandom % 6) != 0);
      if ($urandom % 16 == 0) a = 0;
      if ($urandom % 16 == 0) b = 0;
      step(v, c, a, b);
    end
    for (int n = 0; n < 8; n++) step(0, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule